// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independently clocked ports a way to pass single words to each other. The words do not go through any queue. There are two mailboxes, one for each direction. The outbound mailbox of port A is the inbound mailbox of port B, and the reverse holds for the other mailbox. Each mailbox holds one word of `W` bits.

The port that reads a mailbox sees an active-low "mail waiting" flag in its own clock domain. A put from the writing side pulls that flag low once the put has been synchronized into the reader's clock. A take by the reader returns the flag high on the same edge. The writer sees a busy indication in its own clock. The busy indication stays high from its accepted put until the reader's take has been synchronized back to the writer. While busy is high, further puts are dropped, so an unread word is never overwritten.

The crossing uses one toggle wire in each direction, each passed through a two-flop synchronizer. The put and take strobes come in already decoded from the surrounding port logic. One asynchronous active-low reset clears both mailboxes.

Top module: `mbx_pair`

## Requirements
- R1: While reset is asserted, and right after it is released, both mail flags (`a_mail_n`, `b_mail_n`) are 1 and both busy outputs (`a_outbox_busy`, `b_outbox_busy`) are 0.
- R2: Port A puts a word into mailbox 1 when `a_put` is 1 at a rising `clk_a` edge and `a_outbox_busy` is 0. Within 4 rising `clk_b` edges, `b_mail_n` goes to 0 and `b_take_data` shows that word.
- R3: When `b_take` is 1 at a rising `clk_b` edge and `b_mail_n` is 0, `b_mail_n` is 1 right after that edge.
- R4: A put on port A while `a_outbox_busy` is 1 is ignored. The word held in mailbox 1 is unchanged.
- R5: A take on port B while `b_mail_n` is 1 has no effect. The flag stays 1, and the next put is delivered normally.
- R6: `a_outbox_busy` is 1 right after an accepted put. It returns to 0 within 6 rising `clk_a` edges after port B's take, and after that a new put is accepted.
- R7: Mailbox 2 behaves in the same way with the ports swapped. Port B puts with `b_put`/`b_put_data` and `b_outbox_busy`. Port A reads with `a_mail_n`, `a_take` and `a_take_data`.
- R8: The two mailboxes are independent. Transfers in both directions at the same time each deliver their own word.
- R9: Asserting reset while a word is pending returns both flags to 1 and both busy outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_put | input | 1 | Port A strobe: write mailbox 1 |
| a_put_data | input | W | Word written into mailbox 1 |
| a_outbox_busy | output | 1 | Mailbox 1 not yet released by port B; puts are ignored |
| a_take | input | 1 | Port A strobe: read mailbox 2 |
| a_take_data | output | W | Contents of mailbox 2 |
| a_mail_n | output | 1 | Low while mailbox 2 holds an unread word (clk_a domain) |
| b_put | input | 1 | Port B strobe: write mailbox 2 |
| b_put_data | input | W | Word written into mailbox 2 |
| b_outbox_busy | output | 1 | Mailbox 2 not yet released by port A; puts are ignored |
| b_take | input | 1 | Port B strobe: read mailbox 1 |
| b_take_data | output | W | Contents of mailbox 1 |
| b_mail_n | output | 1 | Low while mailbox 1 holds an unread word (clk_b domain) |

## Verification
The put/take exchange is driven with distinct bit patterns in each direction, such as alternating bits, all ones, and a walking value. A lost or swapped lane, or a crossed mailbox, therefore shows up as a wrong word. A put made into a full mailbox tells a guarded register apart from one that is simply overwritten. A take made against an empty mailbox, followed by a fresh delivery, separates an ignored read from one that flips the handshake out of phase. Puts issued in both directions at the same time, and a reset applied while a word is still pending, show whether the two channels and their flags are kept apart and cleared correctly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_WORD_W  = 36;
    localparam int unsigned MBX_SYNC_FF = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_FF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two or more stages");
    end
endmodule

// File: rtl/mbx_writer.sv
module mbx_writer #(
    parameter int unsigned W      = mbx_pkg::MBX_WORD_W,
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_FF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         put,
    input  logic [W-1:0] put_data,
    input  logic         ack_tgl_async,
    output logic         req_tgl,
    output logic [W-1:0] word,
    output logic         busy
);
    typedef struct packed {
        logic         req;
        logic [W-1:0] data;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      ack_sync;
    logic      accept;

    mbx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_tgl_async),
        .dout (ack_sync)
    );

    always_comb begin
        st_d   = st_q;
        busy   = st_q.req ^ ack_sync;
        accept = put && !busy;
        if (accept) begin
            st_d.req  = ~st_q.req;
            st_d.data = put_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl = st_q.req;
    assign word    = st_q.data;

    assert_put_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !busy) |=> busy);

    assert_blocked_put_keeps_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (put && busy) |=> $stable(word));

    assert_word_held_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(word));
endmodule

// File: rtl/mbx_reader.sv
module mbx_reader #(
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_FF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic req_tgl_async,
    output logic ack_tgl,
    output logic mail_n
);
    typedef struct packed {
        logic ack;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      req_sync;

    mbx_sync #(.STAGES(STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_tgl_async),
        .dout (req_sync)
    );

    always_comb begin
        st_d   = st_q;
        mail_n = ~(req_sync ^ st_q.ack);
        if (take && !mail_n) st_d.ack = ~st_q.ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;

    assert_take_releases_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !mail_n) |=> mail_n);

    assert_idle_take_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mail_n) |=> $stable(ack_tgl));

    assert_flag_falls_only_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mail_n) |-> $changed(req_sync));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned W      = mbx_pkg::MBX_WORD_W,
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_FF
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         put,
    input  logic [W-1:0] put_data,
    output logic         busy,
    input  logic         take,
    output logic [W-1:0] take_data,
    output logic         mail_n
);
    logic req_tgl;
    logic ack_tgl;

    mbx_writer #(.W(W), .STAGES(STAGES)) u_writer (
        .clk          (wr_clk),
        .rst_n        (rst_n),
        .put          (put),
        .put_data     (put_data),
        .ack_tgl_async(ack_tgl),
        .req_tgl      (req_tgl),
        .word         (take_data),
        .busy         (busy)
    );

    mbx_reader #(.STAGES(STAGES)) u_reader (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .take         (take),
        .req_tgl_async(req_tgl),
        .ack_tgl      (ack_tgl),
        .mail_n       (mail_n)
    );
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
    parameter int unsigned W      = mbx_pkg::MBX_WORD_W,
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_FF
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_put,
    input  logic [W-1:0] a_put_data,
    output logic         a_outbox_busy,
    input  logic         a_take,
    output logic [W-1:0] a_take_data,
    output logic         a_mail_n,
    input  logic         b_put,
    input  logic [W-1:0] b_put_data,
    output logic         b_outbox_busy,
    input  logic         b_take,
    output logic [W-1:0] b_take_data,
    output logic         b_mail_n
);
    // mailbox 1: A writes, B reads
    mbx_channel #(.W(W), .STAGES(STAGES)) u_box_ab (
        .wr_clk   (clk_a),
        .rd_clk   (clk_b),
        .rst_n    (rst_n),
        .put      (a_put),
        .put_data (a_put_data),
        .busy     (a_outbox_busy),
        .take     (b_take),
        .take_data(b_take_data),
        .mail_n   (b_mail_n)
    );

    // mailbox 2: B writes, A reads (R7)
    mbx_channel #(.W(W), .STAGES(STAGES)) u_box_ba (
        .wr_clk   (clk_b),
        .rd_clk   (clk_a),
        .rst_n    (rst_n),
        .put      (b_put),
        .put_data (b_put_data),
        .busy     (b_outbox_busy),
        .take     (a_take),
        .take_data(a_take_data),
        .mail_n   (a_mail_n)
    );

    assert_reset_flags_high_R1: assert property (@(posedge clk_a)
        !rst_n |-> (a_mail_n && !a_outbox_busy));

    assert_reset_flags_high_b_R9: assert property (@(posedge clk_b)
        !rst_n |-> (b_mail_n && !b_outbox_busy));
endmodule

// File: tb/mbx_pair_bench.sv
module mbx_pair_bench;
    localparam int W = 36;

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic a_put = 0, a_take = 0, b_put = 0, b_take = 0;
    logic [W-1:0] a_put_data = '0, b_put_data = '0;
    logic a_outbox_busy, a_mail_n, b_outbox_busy, b_mail_n;
    logic [W-1:0] a_take_data, b_take_data;

    int checks = 0, errors = 0;

    always #4   clk_a = ~clk_a;   // 125 MHz
    always #5.5 clk_b = ~clk_b;

    mbx_pair #(.W(W)) u_mbx_pair (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_put(a_put), .a_put_data(a_put_data), .a_outbox_busy(a_outbox_busy),
        .a_take(a_take), .a_take_data(a_take_data), .a_mail_n(a_mail_n),
        .b_put(b_put), .b_put_data(b_put_data), .b_outbox_busy(b_outbox_busy),
        .b_take(b_take), .b_take_data(b_take_data), .b_mail_n(b_mail_n)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (4) @(posedge clk_b);
        @(negedge clk_a);
        rst_n = 1;
        repeat (2) @(negedge clk_b);
    endtask

    task automatic put_a(input logic [W-1:0] d);
        @(negedge clk_a); a_put = 1; a_put_data = d;
        @(negedge clk_a); a_put = 0;
    endtask

    task automatic put_b(input logic [W-1:0] d);
        @(negedge clk_b); b_put = 1; b_put_data = d;
        @(negedge clk_b); b_put = 0;
    endtask

    task automatic take_b(input string req);
        @(negedge clk_b); b_take = 1;
        @(negedge clk_b); b_take = 0;
        check(b_mail_n == 1'b1, req, b_mail_n, 1);
    endtask

    task automatic take_a(input string req);
        @(negedge clk_a); a_take = 1;
        @(negedge clk_a); a_take = 0;
        check(a_mail_n == 1'b1, req, a_mail_n, 1);
    endtask

    task automatic wait_mail_b(input string req);
        bit seen = 0;
        for (int i = 0; i < 4 && !seen; i++) begin
            @(negedge clk_b);
            if (!b_mail_n) seen = 1;
        end
        check(seen, req, b_mail_n, 0);
    endtask

    task automatic wait_mail_a(input string req);
        bit seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            @(negedge clk_a);
            if (!a_mail_n) seen = 1;
        end
        check(seen, req, a_mail_n, 0);
    endtask

    task automatic wait_idle_a(input string req);
        bit idle = 0;
        for (int i = 0; i < 6 && !idle; i++) begin
            @(negedge clk_a);
            if (!a_outbox_busy) idle = 1;
        end
        check(idle, req, a_outbox_busy, 0);
    endtask

    task automatic wait_idle_b(input string req);
        bit idle = 0;
        for (int i = 0; i < 6 && !idle; i++) begin
            @(negedge clk_b);
            if (!b_outbox_busy) idle = 1;
        end
        check(idle, req, b_outbox_busy, 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk_a);
        check(a_mail_n && b_mail_n, "R1 flags in reset", {a_mail_n, b_mail_n}, 2'b11);
        check(!a_outbox_busy && !b_outbox_busy, "R1 busy in reset", {a_outbox_busy, b_outbox_busy}, 0);
        do_reset();
        check(a_mail_n && b_mail_n, "R1 flags after reset", {a_mail_n, b_mail_n}, 2'b11);
        check(!a_outbox_busy && !b_outbox_busy, "R1 busy after reset", {a_outbox_busy, b_outbox_busy}, 0);
    endtask

    task automatic t_a_to_b();
        logic [W-1:0] w = 36'hA_5A5A_5A5A;
        put_a(w);
        check(a_outbox_busy == 1'b1, "R6 busy after put", a_outbox_busy, 1);
        wait_mail_b("R2 flag low");
        check(b_take_data == w, "R2 data", b_take_data, w);
        take_b("R3 take releases flag");
        wait_idle_a("R6 busy clears");
        put_a(36'hF_FFFF_FFFF);
        check(a_outbox_busy == 1'b1, "R6 new put accepted", a_outbox_busy, 1);
        wait_mail_b("R2 second flag low");
        check(b_take_data == 36'hF_FFFF_FFFF, "R2 second data", b_take_data, 36'hF_FFFF_FFFF);
        take_b("R3 second take");
        wait_idle_a("R6 busy clears again");
    endtask

    task automatic t_overwrite_blocked();
        logic [W-1:0] first = 36'h1_2345_6789;
        put_a(first);
        wait_mail_b("R2 flag low before overwrite");
        check(a_outbox_busy == 1'b1, "R4 busy while unread", a_outbox_busy, 1);
        put_a(36'h0_0BAD_0BAD);
        repeat (4) @(negedge clk_b);
        check(b_take_data == first, "R4 word kept", b_take_data, first);
        check(b_mail_n == 1'b0, "R4 flag still low", b_mail_n, 0);
        take_b("R3 take after blocked put");
        wait_idle_a("R6 idle after blocked put");
        check(b_take_data == first, "R4 word after take", b_take_data, first);
    endtask

    task automatic t_idle_take();
        bit stayed = 1;
        logic [W-1:0] w = 36'h8_0000_0001;
        @(negedge clk_b); b_take = 1;
        @(negedge clk_b); b_take = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_b);
            if (!b_mail_n) stayed = 0;
        end
        check(stayed, "R5 flag stays high", b_mail_n, 1);
        put_a(w);
        wait_mail_b("R5 delivery after idle take");
        check(b_take_data == w, "R5 data after idle take", b_take_data, w);
        take_b("R5 take after idle take");
        wait_idle_a("R5 busy clears");
    endtask

    task automatic t_b_to_a();
        logic [W-1:0] w = 36'h5_A5A5_A5A5;
        put_b(w);
        check(b_outbox_busy == 1'b1, "R7 busy after put", b_outbox_busy, 1);
        wait_mail_a("R7 flag low");
        check(a_take_data == w, "R7 data", a_take_data, w);
        take_a("R7 take releases flag");
        wait_idle_b("R7 busy clears");
    endtask

    task automatic t_both();
        logic [W-1:0] wa = 36'h0_0000_0F0F, wb = 36'hC_3C3C_0000;
        fork
            put_a(wa);
            put_b(wb);
        join
        wait_mail_b("R8 flag b low");
        wait_mail_a("R8 flag a low");
        check(b_take_data == wa, "R8 data at B", b_take_data, wa);
        check(a_take_data == wb, "R8 data at A", a_take_data, wb);
        fork
            take_b("R8 take at B");
            take_a("R8 take at A");
        join
        wait_idle_a("R8 A idle");
        wait_idle_b("R8 B idle");
    endtask

    task automatic t_reset_pending();
        put_a(36'h7_7777_7777);
        put_b(36'h3_3333_3333);
        wait_mail_b("R9 pending b");
        wait_mail_a("R9 pending a");
        do_reset();
        check(a_mail_n && b_mail_n, "R9 flags cleared", {a_mail_n, b_mail_n}, 2'b11);
        check(!a_outbox_busy && !b_outbox_busy, "R9 busy cleared", {a_outbox_busy, b_outbox_busy}, 0);
    endtask

    initial begin
        t_reset();
        t_a_to_b();
        t_overwrite_blocked();
        t_idle_take();
        t_b_to_a();
        t_both();
        t_reset_pending();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_a);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule